// File: doc/BRIEF.md
# Four-stage pipelined 8-bit processor core

This block is a small in-order processor with overlapped execution. One instruction word is fetched every cycle from a 16-word instruction store. Each word passes through four stages: fetch, decode with register read, execute with data-memory access, and writeback. The datapath is 8 bits wide. There are four general registers and a four-word data store. The instruction set has four operations: add, subtract, load and store. There are no branches, so the program counter simply counts up and wraps, and the stored program repeats for as long as the core runs.

Both memories can be written through an initialisation port, but only while reset is held. This is how a program and its starting data are placed before execution. The register file and the data store are shown on two debug outputs, so a checker can compare the architectural state against a sequential model cycle by cycle.

Operand hazards never stall the pipeline. The decode stage reads the register file with write-first bypass. The execute stage takes a result straight from the writeback register when the instruction just ahead of it targets one of its sources. Load results come from a combinationally read data store in the execute stage, so they are ready for the next instruction as well.

Top module: `tiny_pipe_cpu`

## Requirements
- R1: Reset clears the stage valid flags and all four registers to zero. Bubbles after reset write neither the registers nor the data store: the data store keeps its preloaded values through the first two cycles after reset, and the registers stay zero through the first three.
- R2: Opcode 00 (word bits 7:6) adds the register in bits 5:4 to the register in bits 3:2 and writes the register in bits 1:0.
- R3: Opcode 01 subtracts the bits 3:2 register from the bits 5:4 register and writes bits 1:0. The 8-bit result wraps modulo 256.
- R4: Opcode 10 loads the data word addressed by bits 3:2 into the register in bits 1:0.
- R5: Opcode 11 stores the register in bits 5:4 into the data word addressed by bits 3:2. The store lands three clock edges after its word is fetched.
- R6: The program counter starts at 0, advances by one every cycle and wraps from 15 to 0, so the program repeats.
- R7: An add or subtract that reads the destination of the add or subtract just ahead of it gets the new value, with no stall.
- R8: An instruction that reads the destination of the load just ahead of it gets the loaded value, with no stall.
- R9: A store whose source register was written by the instruction just ahead of it stores the new value.
- R10: A register write and a read of the same register in the same cycle return the written value (dependency distance two).
- R11: The init port writes instruction words (select 0) or data words (select 1, low two address bits) only while reset is high. When reset is low, init writes have no effect.
- R12: One instruction completes per cycle. Instruction k (counted from 0 after reset) is visible in the registers after clock edge k+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_we | input | 1 | Init write strobe, honoured only in reset |
| init_sel | input | 1 | Init target: 0 instruction store, 1 data store |
| init_addr | input | 4 | Init word address |
| init_data | input | 8 | Init write data |
| dbg_regs | output | 32 | Register i on bits [8i+7:8i] |
| dbg_dmem | output | 32 | Data word i on bits [8i+7:8i] |

## Verification
The bench uses the defaults: an 8-bit datapath and a 16-word instruction store. With 8-bit values, subtraction underflow and addition overflow occur within a few instructions of small seed data. With 16 words, the program counter wraps after 16 cycles, so every run of 40 cycles executes the program more than twice on evolving data. A sequential model produces one expected register snapshot and one expected data snapshot per instruction. The monitor consumes them at the exact edges where each stage writes. The two programs, one hand-written and one generated, place every forwarding distance and every load and store pairing back to back.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int INSN_W     = 8;
  localparam int FLD_W      = 2;
  localparam int NUM_REGS   = 1 << FLD_W;
  localparam int DMEM_WORDS = 1 << FLD_W;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_LD  = 2'b10,
    OP_ST  = 2'b11
  } opc_e;

  typedef struct packed {
    opc_e             op;
    logic [FLD_W-1:0] ra;
    logic [FLD_W-1:0] rb;
    logic [FLD_W-1:0] rd;
  } insn_t;
endpackage

// File: rtl/tpc_imem.sv
module tpc_imem #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tpc_dmem.sv
module tpc_dmem #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [WIDTH-1:0]       wdata,
  output logic [WIDTH-1:0]       rdata,
  output logic [DEPTH*WIDTH-1:0] dump
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_dump
    assign dump[i*WIDTH +: WIDTH] = mem[i];
  end

  // R5
  dm_wr_land_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(addr)] == $past(wdata));
endmodule

// File: rtl/tpc_regfile.sv
module tpc_regfile #(
  parameter int NREG  = 4,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [AW-1:0]         wa,
  input  logic [WIDTH-1:0]      wd,
  input  logic [AW-1:0]         ra1,
  input  logic [AW-1:0]         ra2,
  output logic [WIDTH-1:0]      rd1,
  output logic [WIDTH-1:0]      rd2,
  output logic [NREG*WIDTH-1:0] dump
);
  logic [WIDTH-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  // write-first: a same-cycle write is visible to the reader
  assign rd1 = (we && wa == ra1) ? wd : regs[ra1];
  assign rd2 = (we && wa == ra2) ? wd : regs[ra2];

  for (genvar i = 0; i < NREG; i++) begin : g_dump
    assign dump[i*WIDTH +: WIDTH] = regs[i];
  end

  // R10
  rf_wr_land_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> regs[$past(wa)] == $past(wd));
endmodule

// File: rtl/tpc_alu.sv
module tpc_alu #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             sub,
  output logic [WIDTH-1:0] z
);
  always_comb begin
    if (sub) z = x - y;
    else     z = x + y;
  end
endmodule

// File: rtl/tiny_pipe_cpu.sv
module tiny_pipe_cpu #(
  parameter int DATA_W     = 8,
  parameter int IMEM_DEPTH = 16
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   init_we,
  input  logic                                   init_sel,
  input  logic [$clog2(IMEM_DEPTH)-1:0]          init_addr,
  input  logic [DATA_W-1:0]                      init_data,
  output logic [tpc_pkg::NUM_REGS*DATA_W-1:0]    dbg_regs,
  output logic [tpc_pkg::DMEM_WORDS*DATA_W-1:0]  dbg_dmem
);
  import tpc_pkg::*;

  localparam int PC_W = $clog2(IMEM_DEPTH);

  // fetch
  logic [PC_W-1:0]   pc_q;
  logic [INSN_W-1:0] if_word;

  // decode
  logic        id_vld_q;
  insn_t       id_insn_q;
  logic [DATA_W-1:0] id_a, id_b;

  // execute
  logic        ex_vld_q;
  insn_t       ex_insn_q;
  logic [DATA_W-1:0] ex_a_q, ex_b_q, opa, opb, alu_z, dm_rdata;

  // writeback
  logic              wb_vld_q, wb_wen_q;
  logic [FLD_W-1:0]  wb_rd_q;
  logic [DATA_W-1:0] wb_data_q;
  logic              rf_we;

  // data store port sharing
  logic              dm_we;
  logic [FLD_W-1:0]  dm_addr;
  logic [DATA_W-1:0] dm_wdata;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_q + 1'b1;
  end

  tpc_imem #(.DEPTH(IMEM_DEPTH), .WIDTH(INSN_W)) imem_i (
    .clk   (clk),
    .we    (rst && init_we && !init_sel),
    .waddr (init_addr),
    .wdata (init_data[INSN_W-1:0]),
    .raddr (pc_q),
    .rdata (if_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      id_vld_q <= 1'b0;
      ex_vld_q <= 1'b0;
      wb_vld_q <= 1'b0;
      wb_wen_q <= 1'b0;
    end else begin
      id_vld_q <= 1'b1;
      ex_vld_q <= id_vld_q;
      wb_vld_q <= ex_vld_q;
      wb_wen_q <= ex_vld_q && (ex_insn_q.op != OP_ST);
    end
  end

  always_ff @(posedge clk) begin
    id_insn_q <= insn_t'(if_word);
    ex_insn_q <= id_insn_q;
    ex_a_q    <= id_a;
    ex_b_q    <= id_b;
    wb_rd_q   <= ex_insn_q.rd;
    wb_data_q <= (ex_insn_q.op == OP_LD) ? dm_rdata : alu_z;
  end

  assign rf_we = wb_vld_q && wb_wen_q;

  tpc_regfile #(.NREG(NUM_REGS), .WIDTH(DATA_W)) rf_i (
    .clk  (clk),
    .rst  (rst),
    .we   (rf_we),
    .wa   (wb_rd_q),
    .wd   (wb_data_q),
    .ra1  (id_insn_q.ra),
    .ra2  (id_insn_q.rb),
    .rd1  (id_a),
    .rd2  (id_b),
    .dump (dbg_regs)
  );

  // bypass from the instruction one stage ahead
  assign opa = (rf_we && wb_rd_q == ex_insn_q.ra) ? wb_data_q : ex_a_q;
  assign opb = (rf_we && wb_rd_q == ex_insn_q.rb) ? wb_data_q : ex_b_q;

  tpc_alu #(.WIDTH(DATA_W)) alu_i (
    .x   (opa),
    .y   (opb),
    .sub (ex_insn_q.op == OP_SUB),
    .z   (alu_z)
  );

  assign dm_we    = rst ? (init_we && init_sel) : (ex_vld_q && ex_insn_q.op == OP_ST);
  assign dm_addr  = rst ? init_addr[FLD_W-1:0] : ex_insn_q.rb;
  assign dm_wdata = rst ? init_data : opa;

  tpc_dmem #(.DEPTH(DMEM_WORDS), .WIDTH(DATA_W)) dmem_i (
    .clk   (clk),
    .rst   (rst),
    .we    (dm_we),
    .addr  (dm_addr),
    .wdata (dm_wdata),
    .rdata (dm_rdata),
    .dump  (dbg_dmem)
  );

  // R6
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> pc_q == PC_W'($past(pc_q) + 1'b1));
  // R1
  valid_clr_chk: assert property (@(posedge clk)
    rst |=> !id_vld_q && !ex_vld_q && !wb_vld_q);
  // R12
  ex_chain_chk: assert property (@(posedge clk) disable iff (rst)
    ex_vld_q |-> $past(id_vld_q));
  // R12
  wb_chain_chk: assert property (@(posedge clk) disable iff (rst)
    wb_vld_q |-> $past(ex_vld_q));
endmodule

// File: tb/tiny_pipe_cpu_tb_top.sv
module tiny_pipe_cpu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        init_we = 1'b0;
  logic        init_sel = 1'b0;
  logic [3:0]  init_addr = '0;
  logic [7:0]  init_data = '0;
  logic [31:0] dbg_regs, dbg_dmem;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] mprog [16];
  logic [7:0] mrf [4];
  logic [7:0] mdm [4];
  logic [7:0] seed [4];

  logic [31:0] q_rf[$];
  logic [31:0] q_dm[$];
  string       q_trf[$];
  string       q_tdm[$];

  always #4 clk = ~clk;

  tiny_pipe_cpu dut_i (
    .clk(clk), .rst(rst), .init_we(init_we), .init_sel(init_sel),
    .init_addr(init_addr), .init_data(init_data),
    .dbg_regs(dbg_regs), .dbg_dmem(dbg_dmem)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: sequential model, one expected item per instruction
  task automatic drive_model(int nsteps);
    bit pw1 = 0, pw2 = 0, pld1 = 0;
    logic [1:0] prd1 = '0, prd2 = '0;
    for (int i = 0; i < 4; i++) begin mrf[i] = '0; mdm[i] = seed[i]; end
    for (int i = 0; i < nsteps; i++) begin
      logic [7:0] w;
      logic [1:0] op, ra, rb, rd;
      bit ua, ub, d1, d2;
      string tag;
      w = mprog[i % 16];
      op = w[7:6]; ra = w[5:4]; rb = w[3:2]; rd = w[1:0];
      ua = (op != 2'b10);
      ub = (op[1] == 1'b0);
      d1 = pw1 && ((ua && ra == prd1) || (ub && rb == prd1));
      d2 = pw2 && ((ua && ra == prd2) || (ub && rb == prd2));
      if (i >= 16 && i % 16 == 0) tag = "R6";
      else if (d1) tag = (op == 2'b11) ? "R9" : (pld1 ? "R8" : "R7");
      else if (d2) tag = "R10";
      else case (op)
        2'b00: tag = "R2";
        2'b01: tag = "R3";
        2'b10: tag = "R4";
        default: tag = "R5";
      endcase
      case (op)
        2'b00: mrf[rd] = mrf[ra] + mrf[rb];
        2'b01: mrf[rd] = mrf[ra] - mrf[rb];
        2'b10: mrf[rd] = mdm[rb];
        default: mdm[rb] = mrf[ra];
      endcase
      q_rf.push_back({mrf[3], mrf[2], mrf[1], mrf[0]});
      q_dm.push_back({mdm[3], mdm[2], mdm[1], mdm[0]});
      q_trf.push_back({tag, "/R12"});
      q_tdm.push_back(tag);
      pw2 = pw1; prd2 = prd1;
      pw1 = (op != 2'b11); pld1 = (op == 2'b10); prd1 = rd;
    end
  endtask

  task automatic load_and_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    for (int j = 0; j < 16; j++) begin
      init_we = 1'b1; init_sel = 1'b0; init_addr = 4'(j); init_data = mprog[j];
      @(negedge clk);
    end
    for (int j = 0; j < 4; j++) begin
      init_we = 1'b1; init_sel = 1'b1; init_addr = 4'(j); init_data = seed[j];
      @(negedge clk);
    end
    init_we = 1'b0;
    // R1 reset state, R11 data preloaded during reset
    chk("R1", dbg_regs, 32'h0);
    chk("R11", dbg_dmem, {seed[3], seed[2], seed[1], seed[0]});
    @(negedge clk);
    rst = 1'b0;
  endtask

  // monitor: pops expected items at the edge where each stage writes
  task automatic monitor(int ncyc);
    logic [31:0] e;
    string tg;
    for (int t = 1; t <= ncyc; t++) begin
      @(posedge clk);
      @(negedge clk);
      if (t >= 3) begin
        e = q_dm.pop_front(); tg = q_tdm.pop_front();
        chk((t >= 11 && t <= 16) ? "R11" : tg, dbg_dmem, e);
      end else begin
        chk("R1", dbg_dmem, {seed[3], seed[2], seed[1], seed[0]});
      end
      if (t >= 4) begin
        e = q_rf.pop_front(); tg = q_trf.pop_front();
        chk((t >= 11 && t <= 16) ? "R11" : tg, dbg_regs, e);
      end else begin
        chk("R1", dbg_regs, 32'h0);
      end
      // R11: init writes while running must be ignored
      if (t >= 10 && t <= 12) begin
        init_we = 1'b1; init_sel = t[0]; init_addr = 4'(t); init_data = 8'hFF;
      end else begin
        init_we = 1'b0;
      end
    end
    q_rf.delete(); q_dm.delete(); q_trf.delete(); q_tdm.delete();
  endtask

  initial begin
    logic [15:0] lcg;
    // program 1: hand-placed hazards
    mprog = '{8'h80, 8'h85, 8'h06, 8'h67, 8'hF8, 8'h88, 8'h45, 8'h32,
              8'h17, 8'hEC, 8'h08, 8'hC0, 8'h8D, 8'hD4, 8'h6E, 8'h3B};
    seed  = '{8'h05, 8'hC8, 8'h07, 8'h10};
    load_and_reset();
    drive_model(40);
    monitor(40);

    // program 2: generated words, different seeds
    lcg = 16'h1D3B;
    for (int j = 0; j < 16; j++) begin
      lcg = lcg * 16'd25173 + 16'd13849;
      mprog[j] = lcg[15:8];
    end
    mprog[0] = 8'h80; mprog[1] = 8'h89;
    seed = '{8'hF0, 8'h21, 8'h9A, 8'h03};
    load_and_reset();
    drive_model(40);
    monitor(40);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule